// File: doc/BRIEF.md
# Three-Stage Instruction Sequencer

This block steers instruction flow for a small signal-processing core. It reads one program word per clock and moves each word through three overlapped stages: fetch, decode and execute. Once the pipe is full, a single-word instruction finishes every clock. Some instructions carry a second word, which holds either immediate data or an absolute address. That second word takes its own slot in every stage. A taken jump throws away the word that was fetched behind it, which leaves one empty slot.

Jump targets and indirect data addresses are formed in the decode stage. The values they use are the register file and memory-map bit as they stand before the instruction in execute writes them. Register and mode writes land at the end of the execute stage. An instruction that reads a register written by the instruction just before it therefore sees the old value. There is no forwarding and no interlock. Software must place one instruction between the writer and the reader. A trace port shows which program address occupies each stage and whether that stage holds a live slot.

Top module: `fde_sequencer`

## Requirements
- R1: While reset is held, and until the first clock after its release, the fetch address is 0, the decode and execute stages are empty, the accumulator is 0, the map bit is 0 and all address registers read as 0.
- R2: Exactly one program word is read per clock, at consecutive addresses unless a jump redirects. A word fetched in clock n sits in decode in clock n+1 and in execute in clock n+2. The word at address 0 reaches execute in the third clock after reset is released.
- R3: Instruction format. Bits [15:12] hold the opcode: 0 is no-op, 1 loads an address register, 2 loads the accumulator from data memory, 3 jumps, 4 sets the map bit, and any other value acts as a no-op. Bit 11 set means an extension word follows. Bits [2:0] name the register. A short load takes its value from bits [10:3]. A short jump takes its target from bits [10:0]. The map write takes its value from bit 0.
- R4: The extension word is fetched in the clock after its opcode word and occupies its own slot in each stage. The instruction takes effect, and the retire output pulses, when the extension slot executes. The next instruction is fetched two clocks after the opcode word.
- R5: An address-register write takes effect at the end of execute. A data load whose address is formed in the same clock uses the old value. With one instruction in between, the load uses the new value.
- R6: The map bit is written at the end of execute. The top bit of the data address is the map bit as it stood when the load was decoded, so a load directly after the map write uses the old map.
- R7: A jump is resolved in decode, and the next fetch address is its target. The word fetched while the jump was decoded never executes, and the decode stage is empty for one clock.
- R8: A data load presents {map, address} with the data enable during execute, and the accumulator takes the returned data at the end of that clock. The short form uses the named register as the address. The long form uses the extension word as an absolute address.
- R9: A long jump takes its target from the low program-address bits of its extension word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pmem_addr | output | PAW | Program read address (fetch PC) |
| pmem_rdata | input | 16 | Program word returned in the same clock |
| dmem_en | output | 1 | Data read enable (a load is in execute) |
| dmem_addr | output | DAW+1 | Data read address, map bit on top |
| dmem_rdata | input | 16 | Data word returned in the same clock |
| acc | output | 16 | Accumulator |
| map_sel | output | 1 | Current memory-map bit |
| retire | output | 1 | An instruction completes in execute this clock |
| trc_f_pc | output | PAW | Address in fetch |
| trc_d_valid | output | 1 | Decode stage holds a live slot |
| trc_d_pc | output | PAW | Address in decode |
| trc_e_valid | output | 1 | Execute stage holds a live slot |
| trc_e_pc | output | PAW | Address in execute |

## Verification
The assertions check the local rules of the pipe on every clock. They cover the fetch address stepping or redirecting, live slots moving from decode to execute, the extension slot following its opcode word, the bubble after a jump, and the map bit being written one clock after execute. Only the bench scenarios can show the effects that span instructions. These are the stale register and map reads for a consumer placed right after its producer, the fresh reads one instruction later, the squashed load that never alters a register, and the exact sequence of accumulator values.

// File: rtl/fde_seq_pkg.sv
package fde_seq_pkg;

   localparam int WORD_W = 16;

   localparam logic [3:0] OPC_NOP = 4'h0;
   localparam logic [3:0] OPC_LDI = 4'h1;
   localparam logic [3:0] OPC_LDX = 4'h2;
   localparam logic [3:0] OPC_JMP = 4'h3;
   localparam logic [3:0] OPC_MAP = 4'h4;

   localparam int EXT_BIT = 11;

   typedef enum logic [2:0] {
      K_NOP  = 3'd0,
      K_LDI  = 3'd1,
      K_LDX  = 3'd2,
      K_JMP  = 3'd3,
      K_MAP  = 3'd4,
      K_HALF = 3'd5
   } slot_kind_t;

endpackage

// File: rtl/fde_seq_regfile.sv
module fde_seq_regfile #(
   parameter int NREG     = 8,
   parameter int RW       = 8,
   parameter bit RF_RESET = 1'b1,
   localparam int RIW     = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [RIW-1:0] wr_idx,
   input  logic [RW-1:0]  wr_val,
   input  logic [RIW-1:0] rd_idx,
   output logic [RW-1:0]  rd_val
);

   logic [RW-1:0] regs [NREG];

   generate
      if (RF_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else if (wr_en) begin
               regs[wr_idx] <= wr_val;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_en) regs[wr_idx] <= wr_val;
         end
      end
   endgenerate

   // read sees the array before any write of this clock lands
   assign rd_val = regs[rd_idx];

endmodule

// File: rtl/fde_seq_fetch.sv
module fde_seq_fetch #(
   parameter int PAW = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            redirect,
   input  logic [PAW-1:0]                  redirect_pc,
   input  logic [fde_seq_pkg::WORD_W-1:0]  pmem_rdata,
   output logic [PAW-1:0]                  pc,
   output logic                            d_valid,
   output logic                            d_isext,
   output logic [PAW-1:0]                  d_pc,
   output logic [fde_seq_pkg::WORD_W-1:0]  d_word
);
   import fde_seq_pkg::*;

   logic need_ext;

   // an opcode word in decode that announces a second word
   assign need_ext = d_valid && !d_isext && d_word[EXT_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc      <= '0;
         d_valid <= 1'b0;
         d_isext <= 1'b0;
         d_pc    <= '0;
         d_word  <= '0;
      end else begin
         pc      <= redirect ? redirect_pc : pc + 1'b1;
         d_valid <= !redirect;
         d_isext <= !redirect && need_ext;
         d_pc    <= pc;
         d_word  <= pmem_rdata;
      end
   end

endmodule

// File: rtl/fde_seq_decode.sv
module fde_seq_decode #(
   parameter int PAW  = 12,
   parameter int DAW  = 8,
   parameter int NREG = 8,
   localparam int RIW = $clog2(NREG)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           d_valid,
   input  logic                           d_isext,
   input  logic [fde_seq_pkg::WORD_W-1:0] d_word,
   input  logic                           map_q,
   input  logic [DAW-1:0]                 rd_val,
   output logic [RIW-1:0]                 rd_idx,
   output fde_seq_pkg::slot_kind_t        s_kind,
   output logic [RIW-1:0]                 s_rn,
   output logic [DAW-1:0]                 s_val,
   output logic [DAW:0]                   s_daddr,
   output logic                           redirect,
   output logic [PAW-1:0]                 redirect_pc
);
   import fde_seq_pkg::*;

   logic [3:0]  hold_op;
   logic [10:0] hold_fld;
   logic [3:0]  opc;
   logic [10:0] opf;
   logic        final_slot;
   logic [DAW-1:0] addr_low;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_op  <= '0;
         hold_fld <= '0;
      end else if (d_valid && !d_isext) begin
         hold_op  <= d_word[15:12];
         hold_fld <= d_word[10:0];
      end
   end

   assign opc        = d_isext ? hold_op  : d_word[15:12];
   assign opf        = d_isext ? hold_fld : d_word[10:0];
   assign final_slot = d_isext || !d_word[EXT_BIT];
   assign rd_idx     = opf[RIW-1:0];
   assign s_rn       = opf[RIW-1:0];
   assign addr_low   = d_isext ? d_word[DAW-1:0] : rd_val;
   assign s_daddr    = {map_q, addr_low};
   assign redirect_pc = d_isext ? d_word[PAW-1:0] : PAW'(opf);

   always_comb begin
      s_kind   = K_NOP;
      s_val    = '0;
      redirect = 1'b0;
      if (!final_slot) begin
         s_kind = K_HALF;
      end else begin
         case (opc)
            OPC_LDI: begin
               s_kind = K_LDI;
               s_val  = d_isext ? d_word[DAW-1:0] : DAW'(opf[10:3]);
            end
            OPC_LDX: s_kind = K_LDX;
            OPC_JMP: begin
               s_kind   = K_JMP;
               redirect = d_valid;
            end
            OPC_MAP: begin
               s_kind = K_MAP;
               s_val  = DAW'(opf[0]);
            end
            default: s_kind = K_NOP;
         endcase
      end
   end

endmodule

// File: rtl/fde_seq_execute.sv
module fde_seq_execute #(
   parameter int PAW  = 12,
   parameter int DAW  = 8,
   parameter int NREG = 8,
   localparam int RIW = $clog2(NREG)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           s_valid,
   input  logic [PAW-1:0]                 s_pc,
   input  fde_seq_pkg::slot_kind_t        s_kind,
   input  logic [RIW-1:0]                 s_rn,
   input  logic [DAW-1:0]                 s_val,
   input  logic [DAW:0]                   s_daddr,
   input  logic [fde_seq_pkg::WORD_W-1:0] dmem_rdata,
   output logic                           e_valid,
   output logic [PAW-1:0]                 e_pc,
   output fde_seq_pkg::slot_kind_t        e_kind,
   output logic [DAW-1:0]                 e_val,
   output logic                           wr_en,
   output logic [RIW-1:0]                 wr_idx,
   output logic [DAW-1:0]                 wr_val,
   output logic                           map_q,
   output logic [fde_seq_pkg::WORD_W-1:0] acc_q,
   output logic                           dmem_en,
   output logic [DAW:0]                   dmem_addr,
   output logic                           retire
);
   import fde_seq_pkg::*;

   logic [RIW-1:0] e_rn;
   logic [DAW:0]   e_daddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_valid <= 1'b0;
         e_pc    <= '0;
         e_kind  <= K_NOP;
         e_rn    <= '0;
         e_val   <= '0;
         e_daddr <= '0;
         map_q   <= 1'b0;
         acc_q   <= '0;
      end else begin
         e_valid <= s_valid;
         e_pc    <= s_pc;
         e_kind  <= s_kind;
         e_rn    <= s_rn;
         e_val   <= s_val;
         e_daddr <= s_daddr;
         if (e_valid && e_kind == K_MAP) map_q <= e_val[0];
         if (e_valid && e_kind == K_LDX) acc_q <= dmem_rdata;
      end
   end

   assign wr_en     = e_valid && e_kind == K_LDI;
   assign wr_idx    = e_rn;
   assign wr_val    = e_val;
   assign dmem_en   = e_valid && e_kind == K_LDX;
   assign dmem_addr = e_daddr;
   assign retire    = e_valid && e_kind != K_HALF;

endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer #(
   parameter int PAW      = 12,
   parameter int DAW      = 8,
   parameter int NREG     = 8,
   parameter bit RF_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PAW-1:0]  pmem_addr,
   input  logic [15:0]     pmem_rdata,
   output logic            dmem_en,
   output logic [DAW:0]    dmem_addr,
   input  logic [15:0]     dmem_rdata,
   output logic [15:0]     acc,
   output logic            map_sel,
   output logic            retire,
   output logic [PAW-1:0]  trc_f_pc,
   output logic            trc_d_valid,
   output logic [PAW-1:0]  trc_d_pc,
   output logic            trc_e_valid,
   output logic [PAW-1:0]  trc_e_pc
);
   import fde_seq_pkg::*;

   localparam int RIW = $clog2(NREG);

   if (PAW < 11 || PAW > 16) begin : g_bad_paw
      $error("PAW must lie in 11..16");
   end
   if (DAW < 1 || DAW > 15) begin : g_bad_daw
      $error("DAW must lie in 1..15");
   end
   if (NREG < 2 || NREG > 8 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two in 2..8");
   end

   logic             redirect;
   logic [PAW-1:0]   redirect_pc;
   logic [PAW-1:0]   pc;
   logic             d_valid, d_isext;
   logic [PAW-1:0]   d_pc;
   logic [15:0]      d_word;
   logic [RIW-1:0]   rd_idx, s_rn, wr_idx;
   logic [DAW-1:0]   rd_val, s_val, wr_val, e_val;
   logic [DAW:0]     s_daddr;
   slot_kind_t       s_kind, e_kind;
   logic             e_valid, wr_en, map_q;
   logic [PAW-1:0]   e_pc;

   fde_seq_fetch #(.PAW(PAW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_pc(redirect_pc),
      .pmem_rdata(pmem_rdata), .pc(pc), .d_valid(d_valid), .d_isext(d_isext),
      .d_pc(d_pc), .d_word(d_word)
   );

   fde_seq_decode #(.PAW(PAW), .DAW(DAW), .NREG(NREG)) u_decode (
      .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_isext(d_isext),
      .d_word(d_word), .map_q(map_q), .rd_val(rd_val), .rd_idx(rd_idx),
      .s_kind(s_kind), .s_rn(s_rn), .s_val(s_val), .s_daddr(s_daddr),
      .redirect(redirect), .redirect_pc(redirect_pc)
   );

   fde_seq_regfile #(.NREG(NREG), .RW(DAW), .RF_RESET(RF_RESET)) u_rf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_val(wr_val), .rd_idx(rd_idx), .rd_val(rd_val)
   );

   fde_seq_execute #(.PAW(PAW), .DAW(DAW), .NREG(NREG)) u_exec (
      .clk(clk), .rst_n(rst_n), .s_valid(d_valid), .s_pc(d_pc),
      .s_kind(s_kind), .s_rn(s_rn), .s_val(s_val), .s_daddr(s_daddr),
      .dmem_rdata(dmem_rdata), .e_valid(e_valid), .e_pc(e_pc),
      .e_kind(e_kind), .e_val(e_val), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_val(wr_val), .map_q(map_q), .acc_q(acc), .dmem_en(dmem_en),
      .dmem_addr(dmem_addr), .retire(retire)
   );

   assign pmem_addr   = pc;
   assign map_sel     = map_q;
   assign trc_f_pc    = pc;
   assign trc_d_valid = d_valid;
   assign trc_d_pc    = d_pc;
   assign trc_e_valid = e_valid;
   assign trc_e_pc    = e_pc;

endmodule

// File: rtl/fde_sequencer_chk.sv
module fde_sequencer_chk #(
   parameter int PAW = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    redirect,
   input logic [PAW-1:0]          redirect_pc,
   input logic [PAW-1:0]          pmem_addr,
   input logic                    d_valid,
   input logic                    d_isext,
   input logic                    d_ext_flag,
   input logic [PAW-1:0]          d_pc,
   input logic                    e_valid,
   input logic [PAW-1:0]          e_pc,
   input fde_seq_pkg::slot_kind_t e_kind,
   input logic                    e_val0,
   input logic                    map_q
);
   import fde_seq_pkg::*;

   p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> pmem_addr == PAW'($past(pmem_addr) + 1'b1));

   p_stage_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |=> e_valid && e_pc == $past(d_pc));

   p_ext_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_isext && d_ext_flag) |=>
         d_valid && d_isext && d_pc == PAW'($past(d_pc) + 1'b1));

   p_jump_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !d_valid && pmem_addr == $past(redirect_pc));

   p_map_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && e_kind == K_MAP) |=> map_q == $past(e_val0));

endmodule

bind fde_sequencer fde_sequencer_chk #(.PAW(PAW)) u_chk (
   .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_pc(redirect_pc),
   .pmem_addr(pmem_addr), .d_valid(d_valid), .d_isext(d_isext),
   .d_ext_flag(d_word[11]), .d_pc(d_pc), .e_valid(e_valid), .e_pc(e_pc),
   .e_kind(e_kind), .e_val0(e_val[0]), .map_q(map_q)
);

// File: tb/fde_sequencer_tb.sv
module fde_sequencer_tb_top;
   localparam int CLK_P = 10;
   localparam int PAW = 12;
   localparam int DAW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PAW-1:0] pmem_addr;
   logic [15:0] pmem_rdata;
   logic dmem_en;
   logic [DAW:0] dmem_addr;
   logic [15:0] dmem_rdata;
   logic [15:0] acc;
   logic map_sel, retire, trc_d_valid, trc_e_valid;
   logic [PAW-1:0] trc_f_pc, trc_d_pc, trc_e_pc;

   always #(CLK_P/2) clk = ~clk;

   logic [15:0] prog [64];
   assign pmem_rdata = (pmem_addr < 64) ? prog[pmem_addr[5:0]] : 16'h0000;
   assign dmem_rdata = 16'hD000 ^ {7'b0, dmem_addr};

   fde_sequencer #(.PAW(PAW), .DAW(DAW)) dut_i (
      .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_rdata(pmem_rdata),
      .dmem_en(dmem_en), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
      .acc(acc), .map_sel(map_sel), .retire(retire), .trc_f_pc(trc_f_pc),
      .trc_d_valid(trc_d_valid), .trc_d_pc(trc_d_pc),
      .trc_e_valid(trc_e_valid), .trc_e_pc(trc_e_pc)
   );

   int vecs = 0;
   int fails = 0;

   task automatic chk(input string tag, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference: a two-entry queue, index 0 = execute, 1 = decode
   typedef struct {
      int pc; int w; bit x; bit live; int kind; int rn; int val; int addr;
   } slot_t;
   slot_t q[$];
   int m_pc, mmap, macc;
   int mregs [8];

   function automatic int pword(input int a);
      return (a < 64) ? int'(prog[a]) : 0;
   endfunction

   function automatic slot_t dead();
      slot_t s;
      s.pc = 0; s.w = 0; s.x = 0; s.live = 0; s.kind = -1;
      s.rn = 0; s.val = 0; s.addr = 0;
      return s;
   endfunction

   task automatic model_step();
      slot_t e, d, nf;
      int ow, opc, opf, tgt;
      bit sq;
      e = q[0]; d = q[1]; sq = 0; tgt = 0;
      if (d.live) begin
         ow  = d.x ? e.w : d.w;
         opc = (ow >> 12) & 15;
         opf = ow & 'h7FF;
         d.rn = opf & 7;
         if (!d.x && ((d.w >> 11) & 1) == 1) d.kind = -1;
         else begin
            case (opc)
               1: begin d.kind = 1; d.val = d.x ? (d.w & 'hFF) : ((opf >> 3) & 'hFF); end
               2: begin d.kind = 2;
                        d.addr = mmap * 256 + (d.x ? (d.w & 'hFF) : (mregs[d.rn] & 'hFF)); end
               3: begin d.kind = 3; sq = 1; tgt = d.x ? (d.w & 'hFFF) : opf; end
               4: begin d.kind = 4; d.val = opf & 1; end
               default: d.kind = 0;
            endcase
         end
      end
      if (e.live) begin
         case (e.kind)
            1: mregs[e.rn] = e.val;
            2: macc = 'hD000 ^ e.addr;
            4: mmap = e.val;
            default: ;
         endcase
      end
      nf = dead();
      nf.pc = m_pc;
      nf.w = pword(m_pc);
      nf.x = d.live && !d.x && (((d.w >> 11) & 1) == 1);
      nf.live = !sq;
      q[0] = d;
      q[1] = nf;
      m_pc = sq ? tgt : ((m_pc + 1) & 'hFFF);
   endtask

   int exp_log [8] = '{'hD000, 'hD005, 'hD033, 'hD033, 'hD133, 'hD144, 'hD100, 'hD100};
   int n_log = 0;

   initial begin
      for (int i = 0; i < 64; i++) prog[i] = 16'h0000;
      prog[1]  = 16'h1029; // short load R1 <- 5
      prog[2]  = 16'h2001; // load via R1 right after: stale
      prog[3]  = 16'h2001; // one later: fresh
      prog[4]  = 16'h1802; // long load R2
      prog[5]  = 16'h0033;
      prog[7]  = 16'h2002;
      prog[8]  = 16'h4001; // map <- 1
      prog[9]  = 16'h2002; // old map
      prog[10] = 16'h2002; // new map
      prog[11] = 16'h3014; // short jump to 20
      prog[12] = 16'h13FB; // squashed load of R3
      prog[20] = 16'h2800; // long absolute load
      prog[21] = 16'h0044;
      prog[22] = 16'h2003; // R3 must still be 0
      prog[23] = 16'h3800; // long jump to 48
      prog[24] = 16'h0030;
      prog[25] = 16'h100B; // squashed
      prog[48] = 16'h2003;
      prog[49] = 16'h3031; // jump to self
   end

   initial begin
      bit prev_en, seen_first, seen48, seen12;
      int cyc;
      prev_en = 0; seen_first = 0; seen48 = 0; seen12 = 0; cyc = 0;
      q.delete();
      q.push_back(dead());
      q.push_back(dead());
      m_pc = 0; mmap = 0; macc = 0;
      for (int i = 0; i < 8; i++) mregs[i] = 0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 fetch addr", int'(pmem_addr), 0);
      chk("R1 decode empty", int'(trc_d_valid), 0);
      chk("R1 execute empty", int'(trc_e_valid), 0);
      chk("R1 acc", int'(acc), 0);
      chk("R1 map", int'(map_sel), 0);
      chk("R1 retire", int'(retire), 0);
      rst_n = 1'b1;

      for (int c = 0; c < 70; c++) begin
         @(posedge clk);
         model_step();
         cyc++;
         @(negedge clk);
         if (prev_en) begin
            if (n_log < 8) chk("R5 R6 R8 acc sequence", int'(acc), exp_log[n_log]);
            n_log++;
         end
         prev_en = dmem_en;
         chk("R2 fetch pc", int'(pmem_addr), m_pc);
         chk("R7 decode occupancy", int'(trc_d_valid), int'(q[1].live));
         if (q[1].live) chk("R2 decode pc", int'(trc_d_pc), q[1].pc);
         chk("R2 execute occupancy", int'(trc_e_valid), int'(q[0].live));
         if (q[0].live) chk("R2 execute pc", int'(trc_e_pc), q[0].pc);
         chk("R4 retire", int'(retire), int'(q[0].live && q[0].kind != -1));
         chk("R8 dmem enable", int'(dmem_en), int'(q[0].live && q[0].kind == 2));
         if (q[0].live && q[0].kind == 2) chk("R8 dmem addr", int'(dmem_addr), q[0].addr);
         chk("R5 acc", int'(acc), macc);
         chk("R6 map", int'(map_sel), mmap);
         if (retire && !seen_first) begin
            seen_first = 1;
            chk("R2 first retire cycle", cyc, 2);
            chk("R2 first retire pc", int'(trc_e_pc), 0);
         end
         if (trc_e_valid && trc_e_pc == 48) seen48 = 1;
         if (trc_e_valid && (trc_e_pc == 12 || trc_e_pc == 25)) seen12 = 1;
      end
      chk("R8 load count", n_log, 8);
      chk("R9 long jump reached 48", int'(seen48), 1);
      chk("R7 squashed words never execute", int'(seen12), 0);
      chk("R3 final acc", int'(acc), 'hD100);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 5000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

endmodule